// File: doc/BRIEF.md
# Permissions Table Walker

This block resolves the 2-bit access permission of a 32-bit byte address by walking a three-level permissions table held in memory. The table of the active protection domain starts at the address given on `root_base`. A lookup is offered on a valid/ready request port. The walker then issues word reads one at a time on a memory port and decodes each returned entry. When the walk ends it pulses `done` and presents three results: the permission, a code for the size of the aligned region that the permission covers, and a status. A permission lookaside buffer can be filled from these outputs.

The address splits into a root index in bits [31:22], a second-level index in bits [21:12], a leaf index in bits [11:6] and a word slot in bits [5:2]. A root entry spans 4 MB, a second-level entry spans 4 KB and a leaf entry spans 64 B. Every entry has a type tag in bits [1:0]. For the two pointer types, bits [31:2] give a word-aligned address. An entry can end the walk at any level by giving one permission for the whole span it maps. At the leaf level an entry can instead point to a separate 32-bit vector word that holds sixteen per-word permissions.

Back-pressure rules: a lookup is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the walk ends, so a request offered during that time is neither taken nor remembered. On the memory side, `mem_req_valid` stays high with a fixed `mem_req_addr` until `mem_req_ready` is seen. The response channel and the result outputs have no back-pressure.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and `mem_req_valid` is 0.
- R2: A lookup is accepted when `req_valid` and `req_ready` are both high. `req_ready` is 0 from the next cycle until the cycle of `done`. A request offered while `req_ready` is 0 changes neither the reads that follow nor the result.
- R3: The first read of a walk is at `root_base` (bits [1:0] taken as 0) plus 4 × addr[31:22]. `root_base` is sampled only in the cycle of acceptance.
- R4: An entry of type 00 read at the root or second level makes the next read address equal to {entry[31:2], 00} plus 4 × addr[21:12] (after the root) or plus 4 × addr[11:6] (after the second level).
- R5: A leaf entry of type 01 makes the next read at {entry[31:2], 00}. That word's bits [2k+1:2k], with k = addr[5:2], give the permission, with size code 0 (4 B) and status 0.
- R6: An entry of type 10 ends the walk with permission entry[3:2] and status 0. The size code is 3 (4 MB) at the root, 2 (4 KB) at the second level and 1 (64 B) at the leaf.
- R7: An entry of type 11 (compressed mini-segment) ends the walk with status 1 (unsupported), permission 00 and the size code of its level.
- R8: A type-00 entry at the leaf, or a type-01 entry above the leaf, ends the walk with status 2 (malformed), permission 00 and the size code of its level.
- R9: At most one read is outstanding. `mem_req_valid` holds with a stable word-aligned address until `mem_req_ready`, and it stays low until the response arrives.
- R10: `done` is high for exactly one cycle, the cycle after the final response. The results hold their values until the next `done`. `req_ready` is high in the `done` cycle, so a new lookup can be accepted in that cycle.
- R11: `mem_rsp_valid` is ignored when no read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | Byte address of the active domain's root table |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Walker idle, lookup can be accepted |
| req_addr | input | 32 | Byte address to resolve |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | One-cycle pulse: results valid |
| res_perm | output | 2 | Resolved permission |
| res_size | output | 2 | Covered region: 3 = 4 MB, 2 = 4 KB, 1 = 64 B, 0 = 4 B |
| res_status | output | 2 | 0 ok, 1 unsupported entry, 2 malformed table |

## Verification
Two functions can fall in the same cycle: the end of one walk and the acceptance of the next lookup. In the `done` cycle the walker is already idle. The bench keeps the next lookup queued so that it is offered in exactly that cycle. It expects the result of the old walk on the outputs and the root read of the new walk in the following cycle, so losing either event or merging them is reported. Stray responses are also driven in the same cycle as a pending memory handshake, and junk requests with a changed `root_base` are driven during each walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ET_NEXT = 2'b00,
    ET_VPTR = 2'b01,
    ET_UNIF = 2'b10,
    ET_MINI = 2'b11
  } ent_type_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_UNSUP = 2'd1,
    ST_BAD   = 2'd2
  } walk_status_e;

  typedef enum logic [1:0] {
    ACT_DESCEND = 2'd0,
    ACT_VECTOR  = 2'd1,
    ACT_FINISH  = 2'd2
  } walk_act_e;

  typedef enum logic [1:0] {
    LV_ROOT = 2'd0,
    LV_MID  = 2'd1,
    LV_LEAF = 2'd2,
    LV_VEC  = 2'd3
  } walk_level_e;

  typedef enum logic [1:0] {
    FSM_IDLE  = 2'd0,
    FSM_ISSUE = 2'd1,
    FSM_WAIT  = 2'd2
  } walk_fsm_e;
endpackage

// File: rtl/ptw_addr.sv
module ptw_addr #(
  parameter int L0_W = 10,
  parameter int L1_W = 10,
  parameter int L2_W = 6,
  parameter int SL_W = 4,
  parameter int AW   = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] vaddr,
  input  logic [1:0]    level,
  output logic [AW-1:0] ent_addr
);
  localparam int L2_LSB = 2 + SL_W;
  localparam int L1_LSB = L2_LSB + L2_W;
  localparam int L0_LSB = L1_LSB + L1_W;

  logic [AW-1:0] idx;

  always_comb begin
    idx = '0;
    case (level)
      2'd0:    idx[L0_W-1:0] = vaddr[L0_LSB +: L0_W];
      2'd1:    idx[L1_W-1:0] = vaddr[L1_LSB +: L1_W];
      2'd2:    idx[L2_W-1:0] = vaddr[L2_LSB +: L2_W];
      default: idx = '0;
    endcase
    ent_addr = {base[AW-1:2], 2'b00} + {idx[AW-3:0], 2'b00};
  end
endmodule

// File: rtl/ptw_slot.sv
module ptw_slot #(
  parameter int SL_W = 4
) (
  input  logic [(2<<SL_W)-1:0] vec,
  input  logic [SL_W-1:0]      sel,
  output logic [1:0]           perm
);
  localparam int NSLOT = 1 << SL_W;

  logic [1:0] slots [NSLOT];

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    assign slots[k] = vec[2*k +: 2];
  end

  assign perm = slots[sel];
endmodule

// File: rtl/ptw_decode.sv
module ptw_decode
  import ptw_pkg::*;
(
  input  logic [3:0]   ent_lo,
  input  logic [1:0]   level,
  input  logic [1:0]   slot_perm,
  output walk_act_e    act,
  output logic [1:0]   perm,
  output walk_status_e status
);
  always_comb begin
    act    = ACT_FINISH;
    perm   = 2'b00;
    status = ST_OK;
    if (level == LV_VEC) begin
      perm = slot_perm;
    end else begin
      case (ent_type_e'(ent_lo[1:0]))
        ET_NEXT: begin
          if (level != LV_LEAF) act = ACT_DESCEND;
          else                  status = ST_BAD;
        end
        ET_VPTR: begin
          if (level == LV_LEAF) act = ACT_VECTOR;
          else                  status = ST_BAD;
        end
        ET_UNIF: perm = ent_lo[3:2];
        default: status = ST_UNSUP;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int L0_W = 10,
  parameter int L1_W = 10,
  parameter int L2_W = 6,
  parameter int SL_W = 4,
  localparam int AW  = L0_W + L1_W + L2_W + SL_W + 2,
  localparam int DW  = 2 << SL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] root_base,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          done,
  output logic [1:0]    res_perm,
  output logic [1:0]    res_size,
  output logic [1:0]    res_status
);
  walk_fsm_e     state_q;
  logic [1:0]    lvl_q;
  logic [AW-1:0] va_q;
  logic [AW-1:0] maddr_q;
  logic          done_q;
  logic [1:0]    perm_q, size_q, stat_q;

  logic          idle;
  logic [AW-1:0] ptr;
  logic [AW-1:0] gen_base, gen_va, gen_addr;
  logic [1:0]    gen_lvl, nxt_lvl;
  logic [1:0]    slot_perm, dec_perm;
  walk_act_e     dec_act;
  walk_status_e  dec_stat;

  assign idle = (state_q == FSM_IDLE);
  assign ptr  = AW'({mem_rsp_data[DW-1:2], 2'b00});

  assign nxt_lvl  = (dec_act == ACT_VECTOR) ? 2'(LV_VEC) : 2'(lvl_q + 2'd1);
  assign gen_base = idle ? root_base : ptr;
  assign gen_va   = idle ? req_addr  : va_q;
  assign gen_lvl  = idle ? 2'(LV_ROOT) : nxt_lvl;

  ptw_addr #(.L0_W(L0_W), .L1_W(L1_W), .L2_W(L2_W), .SL_W(SL_W), .AW(AW)) u_addr (
    .base     (gen_base),
    .vaddr    (gen_va),
    .level    (gen_lvl),
    .ent_addr (gen_addr)
  );

  ptw_slot #(.SL_W(SL_W)) u_slot (
    .vec  (mem_rsp_data),
    .sel  (va_q[2 +: SL_W]),
    .perm (slot_perm)
  );

  ptw_decode u_dec (
    .ent_lo    (mem_rsp_data[3:0]),
    .level     (lvl_q),
    .slot_perm (slot_perm),
    .act       (dec_act),
    .perm      (dec_perm),
    .status    (dec_stat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FSM_IDLE;
      lvl_q   <= '0;
      va_q    <= '0;
      maddr_q <= '0;
      done_q  <= 1'b0;
      perm_q  <= '0;
      size_q  <= '0;
      stat_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        FSM_IDLE: begin
          if (req_valid) begin
            va_q    <= req_addr;
            maddr_q <= gen_addr;
            lvl_q   <= 2'(LV_ROOT);
            state_q <= FSM_ISSUE;
          end
        end
        FSM_ISSUE: begin
          if (mem_req_ready) state_q <= FSM_WAIT;
        end
        FSM_WAIT: begin
          if (mem_rsp_valid) begin
            if (dec_act == ACT_FINISH) begin
              done_q  <= 1'b1;
              perm_q  <= dec_perm;
              stat_q  <= 2'(dec_stat);
              size_q  <= 2'd3 - lvl_q;
              state_q <= FSM_IDLE;
            end else begin
              maddr_q <= gen_addr;
              lvl_q   <= nxt_lvl;
              state_q <= FSM_ISSUE;
            end
          end
        end
        default: state_q <= FSM_IDLE;
      endcase
    end
  end

  assign req_ready     = idle;
  assign mem_req_valid = (state_q == FSM_ISSUE);
  assign mem_req_addr  = maddr_q;
  assign done          = done_q;
  assign res_perm      = perm_q;
  assign res_size      = size_q;
  assign res_status    = stat_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_rsp_valid,
  input logic          done,
  input logic [1:0]    res_perm,
  input logic [1:0]    res_size,
  input logic [1:0]    res_status
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n)                              outstanding <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
    else if (mem_rsp_valid)                  outstanding <= 1'b0;
  end

  a_r9_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !mem_req_valid);

  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r9_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || outstanding) |-> !req_ready);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  a_r10_follows_response: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rsp_valid));

  a_r10_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({res_perm, res_size, res_status}));

  // R7 and R8: a failed walk grants no access
  a_r7_fault_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_status != 2'd0) |-> (res_perm == 2'b00));
endmodule

bind ptw_walker ptw_walker_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .done          (done),
  .res_perm      (res_perm),
  .res_size      (res_size),
  .res_status    (res_status)
);

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] root_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done;
  logic [1:0]  res_perm, res_size, res_status;

  always #2 clk = ~clk;

  ptw_walker uut (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .res_perm(res_perm),
    .res_size(res_size), .res_status(res_status)
  );

  localparam logic [31:0] ROOT_A = 32'h0001_0000;
  localparam logic [31:0] ROOT_B = 32'h0001_8000;
  localparam logic [31:0] MIDT   = 32'h0002_0000;
  localparam logic [31:0] LEAFT  = 32'h0003_0000;
  localparam logic [31:0] VECT   = 32'h0004_0000;
  localparam int LIMIT = 100000;

  logic [31:0] mem [bit [31:0]];
  int n_chk = 0, n_fail = 0, cyc = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [1:0]  exp_perm, exp_size, exp_stat;
  string       exp_tag;
  logic [1:0]  last_perm, last_size, last_stat;
  bit          have_res = 0;
  bit          exp_busy = 0, exp_done = 0;
  bit          pending = 0;
  int          lat = 0, gap = 0;
  logic [31:0] req_list [$];
  logic [31:0] root_list [$];
  logic [31:0] cur_root;

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", rq, what, act, expv, cyc);
    end
  endtask

  // Behavioural walk: the reads a lookup must make and the result it must give
  function automatic void walk(logic [31:0] a, logic [31:0] root);
    logic [31:0] e, w;
    bit stop = 0;
    exp_q.delete(); tag_q.delete();
    w = {root[31:2], 2'b00} + (32'(a[31:22]) << 2);
    tag_q.push_back("R3");
    for (int lv = 0; lv < 4 && !stop; lv++) begin
      exp_q.push_back(w);
      if (lv > 0) tag_q.push_back(lv == 3 ? "R5" : "R4");
      e = rd(w);
      exp_size = 2'(3 - lv);
      exp_perm = 2'b00;
      exp_stat = 2'd0;
      if (lv == 3) begin
        exp_perm = e[2*a[5:2] +: 2]; exp_tag = "R5"; stop = 1;
      end else begin
        case (e[1:0])
          2'b00: if (lv < 2) w = {e[31:2], 2'b00} + ((lv == 0 ? 32'(a[21:12]) : 32'(a[11:6])) << 2);
                 else begin exp_stat = 2'd2; exp_tag = "R8"; stop = 1; end
          2'b01: if (lv == 2) w = {e[31:2], 2'b00};
                 else begin exp_stat = 2'd2; exp_tag = "R8"; stop = 1; end
          2'b10: begin exp_perm = e[3:2]; exp_tag = "R6"; stop = 1; end
          default: begin exp_stat = 2'd1; exp_tag = "R7"; stop = 1; end
        endcase
      end
    end
  endfunction

  task automatic tick();
    bit fin = 0, acc = 0;
    @(negedge clk);
    cyc++;
    // observe
    chk(done == exp_done, "R10", "done pulse", 32'(done), 32'(exp_done));
    if (exp_done) begin
      chk(res_perm == exp_perm, exp_tag, "permission", 32'(res_perm), 32'(exp_perm));
      chk(res_size == exp_size, exp_tag, "size code", 32'(res_size), 32'(exp_size));
      chk(res_status == exp_stat, exp_tag, "status", 32'(res_status), 32'(exp_stat));
      last_perm = exp_perm; last_size = exp_size; last_stat = exp_stat; have_res = 1;
    end else if (have_res) begin
      chk({res_perm, res_size, res_status} == {last_perm, last_size, last_stat}, "R10",
          "result hold", 32'({res_perm, res_size, res_status}), 32'({last_perm, last_size, last_stat}));
    end
    chk(req_ready == !exp_busy, "R2", "req_ready", 32'(req_ready), 32'(!exp_busy));
    if (mem_req_valid)
      chk(!pending && exp_busy, "R9", "read while outstanding or idle", 32'(pending), 32'(0));
    // drive: response channel
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'hDEAD_BEEF;
    if (pending) begin
      if (lat == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
        pending = 0;
        fin = (exp_q.size() == 0);
      end else lat--;
    end else if (cyc % 5 == 0) begin
      mem_rsp_valid = 1'b1;           // R11 stray response
      mem_rsp_data  = 32'h0000_000E;
    end
    // drive: request channel of the memory
    mem_req_ready = (cyc % 4 != 1);
    if (mem_req_valid && mem_req_ready) begin
      if (exp_q.size() == 0) chk(0, "R9", "unexpected read", mem_req_addr, 32'h0);
      else begin
        chk(mem_req_addr == exp_q[0], tag_q[0], "read address", mem_req_addr, exp_q[0]);
        pending = 1;
        lat = cyc % 3;
      end
    end
    // drive: lookups
    if (!exp_busy && gap > 0) gap--;
    if (!exp_busy && gap == 0 && req_list.size() > 0) begin
      req_addr  = req_list.pop_front();
      cur_root  = root_list.pop_front();
      root_base = cur_root;
      req_valid = 1'b1;
      walk(req_addr, cur_root);
      acc = 1;
      gap = (req_list.size() % 3 == 0) ? 2 : 0;
    end else if (exp_busy) begin
      req_valid = (cyc % 3 == 0);     // R2 ignored while busy
      req_addr  = 32'h0080_0000 ^ (cyc << 6);
      root_base = (cyc % 2) ? ROOT_A : ROOT_B;   // R3 not sampled mid-walk
    end else begin
      req_valid = 1'b0;
    end
    exp_done = fin;
    if (acc) exp_busy = 1;
    else if (fin) exp_busy = 0;
  endtask

  function automatic logic [31:0] va(int i0, int i1, int i2, int sl);
    return (32'(i0) << 22) | (32'(i1) << 12) | (32'(i2) << 6) | (32'(sl) << 2);
  endfunction

  initial begin
    // root table A
    mem[ROOT_A + 4*1] = MIDT;                   // next-level pointer
    mem[ROOT_A + 4*2] = 32'h0000_000E;          // uniform, perm 3
    mem[ROOT_A + 4*3] = 32'h0000_0003;          // mini-segment
    mem[ROOT_A + 4*4] = VECT | 32'h1;           // vector pointer above leaf
    // root table B
    mem[ROOT_B + 4*1] = 32'h0000_0006;          // uniform, perm 1
    mem[ROOT_B + 4*2] = MIDT;
    for (int i = 0; i < 1024; i++) begin
      case (i % 4)
        0: mem[MIDT + 4*i] = LEAFT;
        1: mem[MIDT + 4*i] = VECT | 32'h1;
        2: mem[MIDT + 4*i] = (32'(i) << 4) | (32'((i / 4) % 4) << 2) | 32'h2;
        default: mem[MIDT + 4*i] = (32'(i) << 4) | 32'h3;
      endcase
    end
    for (int i = 0; i < 64; i++) begin
      case (i % 4)
        0: mem[LEAFT + 4*i] = 32'(i) << 8;
        1: mem[LEAFT + 4*i] = (VECT + 32'(4*i)) | 32'h1;
        2: mem[LEAFT + 4*i] = (32'(i) << 4) | (32'(i % 4) << 2) | 32'h2;
        default: mem[LEAFT + 4*i] = 32'h3;
      endcase
      mem[VECT + 4*i] = $urandom();
    end
    mem[VECT + 4*1] = 32'hC000_0002;            // slot 0 = 2, slot 15 = 3

    // directed lookups
    req_list.push_back(va(1, 0, 1, 0));  root_list.push_back(ROOT_A); // R5
    req_list.push_back(va(1, 0, 1, 15)); root_list.push_back(ROOT_A); // R5
    req_list.push_back(va(2, 9, 3, 1));  root_list.push_back(ROOT_A); // R6 root
    req_list.push_back(va(1, 2, 0, 0));  root_list.push_back(ROOT_A); // R6 mid
    req_list.push_back(va(1, 0, 2, 5));  root_list.push_back(ROOT_A); // R6 leaf
    req_list.push_back(va(1, 0, 3, 0));  root_list.push_back(ROOT_A); // R7 leaf
    req_list.push_back(va(3, 0, 0, 0));  root_list.push_back(ROOT_A); // R7 root
    req_list.push_back(va(4, 0, 0, 0));  root_list.push_back(ROOT_A); // R8 root
    req_list.push_back(va(1, 0, 0, 0));  root_list.push_back(ROOT_A); // R8 leaf
    req_list.push_back(va(1, 1, 0, 0));  root_list.push_back(ROOT_A); // R8 mid
    req_list.push_back(va(7, 5, 5, 5));  root_list.push_back(ROOT_A); // empty tables
    req_list.push_back(va(1, 0, 1, 0));  root_list.push_back(ROOT_B); // R3 domain B
    req_list.push_back(va(2, 4, 1, 7));  root_list.push_back(ROOT_B); // R4 domain B
    for (int i = 0; i < 60; i++) begin
      int pick[5] = '{1, 1, 2, 3, 4};
      req_list.push_back(va(pick[i % 5], int'($urandom_range(1023)),
                            int'($urandom_range(63)), int'($urandom_range(15))));
      root_list.push_back((i % 2) ? ROOT_B : ROOT_A);
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'h1);
    chk(done == 1'b0, "R1", "done after reset", 32'(done), 32'h0);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 32'(mem_req_valid), 32'h0);

    while ((req_list.size() > 0 || exp_busy || exp_done) && cyc < LIMIT) tick();
    repeat (4) tick();
    if (cyc >= LIMIT) chk(0, "R10", "watchdog expired", 32'(cyc), 32'(LIMIT));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule